// File: doc/BRIEF.md
# Root Hub Downstream Port Status

This block holds the status and control state of one downstream port of a USB root hub and presents it as a single 32-bit register word. A read shows the live port state: connection, enable, suspend, over-current, reset in progress, power and attached-device speed. A write does not store the word. Each written 1 in the low half issues a separate command, and the command behind a bit position differs from the state that the same position reports on read. The upper half holds five latched change flags. Hardware events set them and software clears them by writing 1.

The port takes a connect detect, a low-speed detect and an over-current pin. A control input sets the over-current pin polarity. Two pulses arrive from the line-signalling logic: one when a port reset completes and one when a resume completes. The block drives the port power enable, with its own polarity control, a port-reset request held while reset is active, and a registered status-change signal toward the interrupt logic. Line signalling and the timing of reset and resume are handled elsewhere.

Top module: `rh_port_status`

## Requirements
- R1: After reset the read word is 0, port_reset_o and status_chg_o are 0, and port_power_o equals pwr_active_low_i (power off).
- R2: Read bit 0 shows connect_i one cycle after it is sampled. Any change of connect_i sets the connect-change flag, read bit 16.
- R3: Writing 1 to bit 0 clears port enable (read bit 1) and does not set the enable-change flag, read bit 17.
- R4: Writing 1 to bit 1 sets port enable when a device is connected. Writing 1 to bit 1, 2 or 4 while nothing is connected leaves enable, suspend and reset unchanged and sets read bit 16 instead.
- R5: Writing 1 to bit 2 sets suspend (read bit 2). Writing 1 to bit 3 clears suspend and starts a resume. A resume_done_i pulse during suspend or resume sets the resume-complete flag, read bit 18. At other times the pulse is ignored.
- R6: Writing 1 to bit 4 sets reset-active (read bit 4) and port_reset_o. A reset_done_i pulse during reset clears it, sets enable and sets the reset-complete flag, read bit 20. At other times the pulse is ignored.
- R7: Writing 1 to bit 8 sets port power (read bit 8), and writing 1 to bit 9 clears it. If both are written together, clear wins. port_power_o is read bit 8 XOR pwr_active_low_i.
- R8: Read bit 3 shows oc_pin_i XOR oc_active_low_i, registered. Every change of it sets the over-current-change flag, read bit 19. An over-current onset clears power and enable, and sets read bit 17 if the port was enabled.
- R9: Read bit 9 shows low_speed_i, registered, and only while read bit 0 is 1. Otherwise it reads 0.
- R10: A disconnect clears enable, suspend and reset, and sets read bit 17 if the port was enabled.
- R11: Flags 16 to 20 stay set until a 1 is written to their bit. Writing 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R12: status_chg_o is the OR of the five change flags, delayed by one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for wr_data_i |
| wr_data_i | input | DATA_W | Command and clear word |
| rd_data_o | output | DATA_W | Port status word |
| connect_i | input | 1 | Device connect detect |
| low_speed_i | input | 1 | Low-speed device detect |
| oc_pin_i | input | 1 | Over-current pin |
| oc_active_low_i | input | 1 | 1: over-current pin is active low |
| pwr_active_low_i | input | 1 | 1: power output is active low |
| reset_done_i | input | 1 | Pulse: port reset signalling finished |
| resume_done_i | input | 1 | Pulse: resume signalling finished |
| port_power_o | output | 1 | Port power enable at the selected polarity |
| port_reset_o | output | 1 | Port reset request |
| status_chg_o | output | 1 | Registered OR of the change flags |

## Verification
The bench builds the block with the default DATA_W of 32, so every command bit and change flag lands at its defined position. Both polarity controls are switched at run time. This reaches an over-current onset produced by flipping only the polarity input, and a power output that inverts with no state change. Directed sequences cover commands rejected while disconnected, a disconnect in the same cycle as a flag clear, and completion pulses that arrive when nothing is pending.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  // read / command bit positions within the port word
  localparam int B_CONN = 0;
  localparam int B_EN   = 1;
  localparam int B_SUSP = 2;
  localparam int B_OC   = 3;
  localparam int B_RST  = 4;
  localparam int B_PWR  = 8;
  localparam int B_LS   = 9;
  localparam int CHG_BASE = 16;
  localparam int NUM_CHG  = 5;
  // change flag indices, offset by CHG_BASE in the word
  localparam int C_CONN = 0;
  localparam int C_EN   = 1;
  localparam int C_SUSP = 2;
  localparam int C_OC   = 3;
  localparam int C_RST  = 4;

  typedef struct packed {
    logic clr_en;
    logic set_en;
    logic set_susp;
    logic clr_susp;
    logic set_rst;
    logic set_pwr;
    logic clr_pwr;
  } port_cmd_t;
endpackage

// File: rtl/rh_port_decode.sv
module rh_port_decode
  import rh_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output port_cmd_t         cmd_o,
  output logic [NUM_CHG-1:0] w1c_o
);
  always_comb begin
    cmd_o          = '0;
    cmd_o.clr_en   = wr_en_i & wr_data_i[B_CONN];
    cmd_o.set_en   = wr_en_i & wr_data_i[B_EN];
    cmd_o.set_susp = wr_en_i & wr_data_i[B_SUSP];
    cmd_o.clr_susp = wr_en_i & wr_data_i[B_OC];
    cmd_o.set_rst  = wr_en_i & wr_data_i[B_RST];
    cmd_o.set_pwr  = wr_en_i & wr_data_i[B_PWR];
    cmd_o.clr_pwr  = wr_en_i & wr_data_i[B_LS];
  end

  for (genvar g = 0; g < NUM_CHG; g++) begin : g_w1c
    assign w1c_o[g] = wr_en_i & wr_data_i[CHG_BASE+g];
  end
endmodule

// File: rtl/rh_port_ctrl.sv
module rh_port_ctrl
  import rh_port_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  port_cmd_t          cmd_i,
  input  logic               connect_i,
  input  logic               low_speed_i,
  input  logic               oc_act_i,
  input  logic               reset_done_i,
  input  logic               resume_done_i,
  output logic               conn_o,
  output logic               en_o,
  output logic               susp_o,
  output logic               oc_o,
  output logic               rst_o,
  output logic               pwr_o,
  output logic               ls_o,
  output logic [NUM_CHG-1:0] evt_o
);
  logic conn_q, en_q, susp_q, oc_q, rst_q, pwr_q, ls_q, resume_q;
  logic en_d, susp_d, rst_d, pwr_d, resume_d;
  logic oc_rise, disc;

  assign oc_rise = oc_act_i & ~oc_q;
  assign disc    = conn_q & ~connect_i;

  always_comb begin
    en_d     = en_q;
    susp_d   = susp_q;
    rst_d    = rst_q;
    pwr_d    = pwr_q;
    resume_d = resume_q;
    evt_o    = '0;
    // software commands
    if (cmd_i.clr_en) en_d = 1'b0;
    if (cmd_i.set_en) begin
      if (conn_q) en_d = 1'b1;
      else evt_o[C_CONN] = 1'b1;
    end
    if (cmd_i.set_susp) begin
      if (conn_q) susp_d = 1'b1;
      else evt_o[C_CONN] = 1'b1;
    end
    if (cmd_i.clr_susp && susp_q) begin
      susp_d   = 1'b0;
      resume_d = 1'b1;
    end
    if (cmd_i.set_rst) begin
      if (conn_q) rst_d = 1'b1;
      else evt_o[C_CONN] = 1'b1;
    end
    if (cmd_i.set_pwr) pwr_d = 1'b1;
    if (cmd_i.clr_pwr) pwr_d = 1'b0;
    // hardware events override software
    if (reset_done_i && rst_q) begin
      rst_d         = 1'b0;
      en_d          = 1'b1;
      evt_o[C_RST]  = 1'b1;
    end
    if (resume_done_i && (susp_q || resume_q)) begin
      susp_d        = 1'b0;
      resume_d      = 1'b0;
      evt_o[C_SUSP] = 1'b1;
    end
    if (oc_act_i != oc_q) evt_o[C_OC] = 1'b1;
    if (oc_rise) begin
      pwr_d = 1'b0;
      en_d  = 1'b0;
      if (en_q) evt_o[C_EN] = 1'b1;
    end
    if (connect_i != conn_q) evt_o[C_CONN] = 1'b1;
    if (disc) begin
      en_d     = 1'b0;
      susp_d   = 1'b0;
      rst_d    = 1'b0;
      resume_d = 1'b0;
      if (en_q) evt_o[C_EN] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q   <= 1'b0;
      en_q     <= 1'b0;
      susp_q   <= 1'b0;
      oc_q     <= 1'b0;
      rst_q    <= 1'b0;
      pwr_q    <= 1'b0;
      ls_q     <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      conn_q   <= connect_i;
      en_q     <= en_d;
      susp_q   <= susp_d;
      oc_q     <= oc_act_i;
      rst_q    <= rst_d;
      pwr_q    <= pwr_d;
      ls_q     <= low_speed_i;
      resume_q <= resume_d;
    end
  end

  assign conn_o = conn_q;
  assign en_o   = en_q;
  assign susp_o = susp_q;
  assign oc_o   = oc_q;
  assign rst_o  = rst_q;
  assign pwr_o  = pwr_q;
  assign ls_o   = ls_q & conn_q;

  // R10
  disc_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conn_q |-> (!en_q && !susp_q && !rst_q));

  // R6
  rst_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_q && reset_done_i && connect_i && !oc_rise) |=> (!rst_q && en_q));

  // R8
  oc_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_rise |=> (!pwr_q && !en_q));
endmodule

// File: rtl/rh_port_chg.sv
module rh_port_chg
  import rh_port_pkg::*;
#(
  parameter int N = NUM_CHG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic         any_o
);
  logic [N-1:0] flag_q;
  logic         any_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // set has priority over software clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end

    // R11
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_q <= 1'b0;
    else         any_q <= |flag_q;
  end

  assign flag_o = flag_q;
  assign any_o  = any_q;

  // R12
  chg_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_q) |=> any_o);
  // R12
  chg_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|flag_q) |=> !any_o);
endmodule

// File: rtl/rh_port_status.sv
module rh_port_status
  import rh_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              connect_i,
  input  logic              low_speed_i,
  input  logic              oc_pin_i,
  input  logic              oc_active_low_i,
  input  logic              pwr_active_low_i,
  input  logic              reset_done_i,
  input  logic              resume_done_i,
  output logic              port_power_o,
  output logic              port_reset_o,
  output logic              status_chg_o
);
  localparam int MIN_W = CHG_BASE + NUM_CHG;

  port_cmd_t          cmd;
  logic [NUM_CHG-1:0] w1c, evt, flags;
  logic conn, en, susp, oc, rst, pwr, ls;

  rh_port_decode #(.DATA_W(DATA_W)) u_decode (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cmd_o     (cmd),
    .w1c_o     (w1c)
  );

  rh_port_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd),
    .connect_i     (connect_i),
    .low_speed_i   (low_speed_i),
    .oc_act_i      (oc_pin_i ^ oc_active_low_i),
    .reset_done_i  (reset_done_i),
    .resume_done_i (resume_done_i),
    .conn_o        (conn),
    .en_o          (en),
    .susp_o        (susp),
    .oc_o          (oc),
    .rst_o         (rst),
    .pwr_o         (pwr),
    .ls_o          (ls),
    .evt_o         (evt)
  );

  rh_port_chg #(.N(NUM_CHG)) u_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt),
    .clr_i  (w1c),
    .flag_o (flags),
    .any_o  (status_chg_o)
  );

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[B_CONN] = conn;
    rd_data_o[B_EN]   = en;
    rd_data_o[B_SUSP] = susp;
    rd_data_o[B_OC]   = oc;
    rd_data_o[B_RST]  = rst;
    rd_data_o[B_PWR]  = pwr;
    rd_data_o[B_LS]   = ls;
    rd_data_o[CHG_BASE +: NUM_CHG] = flags;
  end

  assign port_power_o = pwr ^ pwr_active_low_i;
  assign port_reset_o = rst;

  // R9
  ls_conn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_LS] |-> rd_data_o[B_CONN]);

  initial begin
    width_chk: assert (DATA_W >= MIN_W);
  end
endmodule

// File: tb/rh_port_status_tb_top.sv
`timescale 1ns/1ps
module rh_port_status_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        connect_i = 1'b0, low_speed_i = 1'b0, oc_pin_i = 1'b0;
  logic        oc_active_low_i = 1'b0, pwr_active_low_i = 1'b0;
  logic        reset_done_i = 1'b0, resume_done_i = 1'b0;
  logic        port_power_o, port_reset_o, status_chg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rh_port_status #(.DATA_W(32)) dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
    .connect_i, .low_speed_i, .oc_pin_i, .oc_active_low_i, .pwr_active_low_i,
    .reset_done_i, .resume_done_i, .port_power_o, .port_reset_o, .status_chg_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    cyc();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse_reset_done();
    reset_done_i = 1'b1; cyc(); reset_done_i = 1'b0;
  endtask

  task automatic pulse_resume_done();
    resume_done_i = 1'b1; cyc(); resume_done_i = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 word", rd_data_o, 32'h0);
    chk("R1 power", {31'b0, port_power_o}, 32'h0);
    chk("R1 reset req", {31'b0, port_reset_o}, 32'h0);
    chk("R1 chg", {31'b0, status_chg_o}, 32'h0);
  endtask

  task automatic t_no_connect();
    wr(32'h0000_0016);
    chk("R4 rejected cmds", rd_data_o, 32'h0001_0000);
    chk("R12 lag", {31'b0, status_chg_o}, 32'h0);
    cyc();
    chk("R12 chg up", {31'b0, status_chg_o}, 32'h1);
    wr(32'h0001_0000);
    chk("R11 clear", rd_data_o, 32'h0);
    cyc();
    chk("R12 chg down", {31'b0, status_chg_o}, 32'h0);
  endtask

  task automatic t_connect();
    connect_i = 1'b1; low_speed_i = 1'b1;
    cyc();
    chk("R2 R9 connect", rd_data_o, 32'h0001_0201);
    wr(32'h0);
    chk("R11 zero write", rd_data_o, 32'h0001_0201);
    wr(32'h0001_0000);
    chk("R2 flag cleared", rd_data_o, 32'h0000_0201);
  endtask

  task automatic t_port_reset();
    wr(32'h0000_0010);
    chk("R6 reset active", rd_data_o, 32'h0000_0211);
    chk("R6 reset req", {31'b0, port_reset_o}, 32'h1);
    pulse_reset_done();
    chk("R6 reset done", rd_data_o, 32'h0010_0203);
    chk("R6 req low", {31'b0, port_reset_o}, 32'h0);
    wr(32'h0010_0000);
    pulse_reset_done();
    chk("R6 stray done", rd_data_o, 32'h0000_0203);
  endtask

  task automatic t_suspend();
    wr(32'h0000_0004);
    chk("R5 suspend", rd_data_o, 32'h0000_0207);
    wr(32'h0000_0008);
    chk("R5 resume start", rd_data_o, 32'h0000_0203);
    pulse_resume_done();
    chk("R5 resume done", rd_data_o, 32'h0004_0203);
    wr(32'h0004_0000);
    pulse_resume_done();
    chk("R5 stray resume", rd_data_o, 32'h0000_0203);
  endtask

  task automatic t_sw_disable();
    wr(32'h0000_0001);
    chk("R3 sw disable", rd_data_o, 32'h0000_0201);
    wr(32'h0000_0002);
    chk("R4 enable", rd_data_o, 32'h0000_0203);
  endtask

  task automatic t_power();
    wr(32'h0000_0100);
    chk("R7 power on", rd_data_o, 32'h0000_0303);
    chk("R7 pin high", {31'b0, port_power_o}, 32'h1);
    pwr_active_low_i = 1'b1; #1;
    chk("R7 pin active low", {31'b0, port_power_o}, 32'h0);
    pwr_active_low_i = 1'b0;
    cyc();
    wr(32'h0000_0300);
    chk("R7 clear wins", rd_data_o, 32'h0000_0203);
    wr(32'h0000_0100);
    chk("R7 power again", rd_data_o, 32'h0000_0303);
  endtask

  task automatic t_overcurrent();
    oc_pin_i = 1'b1; cyc();
    chk("R8 onset", rd_data_o, 32'h000A_0209);
    chk("R8 pin off", {31'b0, port_power_o}, 32'h0);
    oc_pin_i = 1'b0; cyc();
    chk("R8 release", rd_data_o, 32'h000A_0201);
    wr(32'h000A_0000);
    chk("R11 multi clear", rd_data_o, 32'h0000_0201);
    oc_active_low_i = 1'b1; cyc();
    chk("R8 polarity onset", rd_data_o, 32'h0008_0209);
    oc_active_low_i = 1'b0; cyc();
    chk("R8 polarity release", rd_data_o, 32'h0008_0201);
    wr(32'h0008_0000);
    chk("R8 cleared", rd_data_o, 32'h0000_0201);
  endtask

  task automatic t_disconnect();
    wr(32'h0000_0002);
    chk("R4 re-enable", rd_data_o, 32'h0000_0203);
    connect_i = 1'b0;
    wr(32'h0001_0000);
    chk("R10 R11 disconnect", rd_data_o, 32'h0003_0000);
    chk("R9 ls hidden", {31'b0, rd_data_o[9]}, 32'h0);
    wr(32'h0003_0000);
    chk("R11 final clear", rd_data_o, 32'h0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    t_reset_state();
    t_no_connect();
    t_connect();
    t_port_reset();
    t_suspend();
    t_sw_disable();
    t_power();
    t_overcurrent();
    t_disconnect();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule